// File: doc/BRIEF.md
# Fractional Baud Tick Generator with Serial Transmitter

The block builds a serial bit clock whose average rate is a fraction of a timer clock. It does this by swallowing pulses rather than by dividing. Two compare-match timers run from the system clock, and each one drives a pulse-width waveform. The first timer has a short period and gives a fast, roughly square clock. The second timer has a longer period and is high for only part of it, so it acts as a gate. The block ANDs the two waveforms. Each rising edge of the result becomes a one-cycle tick on `base_tick`. With a fast period of 8 cycles and a gate that is high for 24 of every 32 cycles, three of every four fast pulses get through. The average tick rate is therefore 3/32 of the system clock.

A transmitter spends 16 ticks on each serial bit and sends a 10-bit frame. The timer path is used only when asynchronous operation, external clocking and the timer source are all selected. In every other case, the ticks come from rising edges of a plain external clock input. Compare values can be written only while the timers are stopped. A single run bit then releases both counters from zero in the same cycle, so the phase between the two waveforms is always the same.

Top module: `fracbaud_tx`

## Requirements
- R1: After reset, `txd` is 1, `tx_busy` is 0 and `base_tick` is 0.
- R2: While running, each timer counts from 0 up to its top value and then wraps to 0. Its waveform goes high after the count equals top and goes low after the count equals low. With the gate held high (gate top = 0), the timer source gives one tick every fast-top+1 cycles: 4 ticks per 32 cycles for top 7, and 8 ticks per 32 cycles for top 3.
- R3: With fast top/low = 7/3 and gate top/low = 31/23, any 32 consecutive cycles in steady state contain exactly 3 ticks, and no two ticks fall in adjacent cycles.
- R4: While `run` is 0 and the timer source is selected, `base_tick` stays 0.
- R5: `cfg_load` writes the four compare values only while `run` is 0. A load while running has no effect.
- R6: The timer source is used only when `async_mode`, `ext_sel` and `tmr_sel` are all 1. Otherwise, `base_tick` pulses for one cycle on each rising edge of `ext_clk`.
- R7: A frame consists of a 0 start bit, then 8 data bits with the LSB first, then a 1 stop bit. Each bit lasts 16 ticks.
- R8: An idle transmitter accepts `tx_valid`, and `tx_busy` rises in the next cycle. `tx_busy` falls after the 160th tick. Requests made while busy are ignored.
- R9: With the 3/32 source of R3 in steady state, a frame takes between 1696 and 1714 system cycles from the rise of `tx_busy` to its fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | 1 runs both timers; 0 stops them and clears them to zero |
| cfg_load | input | 1 | Writes the compare values while stopped |
| fast_top | input | CW | Wrap value of the fast timer |
| fast_low | input | CW | Count at which the fast waveform goes low |
| gate_top | input | CW | Wrap value of the gate timer |
| gate_low | input | CW | Count at which the gate waveform goes low |
| async_mode | input | 1 | Asynchronous operation qualifier |
| ext_sel | input | 1 | External clock input chosen |
| tmr_sel | input | 1 | Timer source requested |
| ext_clk | input | 1 | Plain external base clock |
| tx_valid | input | 1 | Request to send `tx_data` |
| tx_data | input | 8 | Byte to send |
| base_tick | output | 1 | One-cycle base clock tick |
| tx_busy | output | 1 | A frame is being sent |
| txd | output | 1 | Serial line, idle high |

## Verification
The tick source is tried with four kinds of input. First, the gate is held high, which shows the fast timer's period alone and rules out a design that ignores the fast compare values. Second, the 8/32 compare pair is used, where only correct AND gating gives 3 ticks rather than 4. Third, the timers are stopped and loads are attempted while running, which separates a run gate or load gate that works from one that leaks. Fourth, the select inputs are swept against a toggling external clock, which shows whether the qualifier really needs all three bits. Two different bytes are sent over the fractional source. Their bits are compared at mid-bit, a second request is made mid-frame, and the frame length in cycles is measured. Together these distinguish bit order, framing, request handling and the fractional average rate.

// File: rtl/fracbaud_tx.sv
module fracbaud_tx #(
  parameter int CW = 8,
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic                 cfg_load,
  input  logic [CW-1:0]        fast_top,
  input  logic [CW-1:0]        fast_low,
  input  logic [CW-1:0]        gate_top,
  input  logic [CW-1:0]        gate_low,
  input  logic                 async_mode,
  input  logic                 ext_sel,
  input  logic                 tmr_sel,
  input  logic                 ext_clk,
  input  logic                 tx_valid,
  input  logic [DATA_BITS-1:0] tx_data,
  output logic                 base_tick,
  output logic                 tx_busy,
  output logic                 txd
);
  localparam int FW  = DATA_BITS + 2;
  localparam int TCW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int BCW = $clog2(FW);
  localparam logic [TCW-1:0] T_LAST = TCW'(TICKS_PER_BIT - 1);
  localparam logic [BCW-1:0] B_LAST = BCW'(FW - 1);

  logic [CW-1:0] f_top, f_low, g_top, g_low;
  logic [CW-1:0] f_cnt, g_cnt;
  logic f_pw, g_pw, and_q, ext_q;
  logic [FW-1:0] shreg;
  logic [TCW-1:0] tcnt;
  logic [BCW-1:0] bcnt;

  wire use_tmr  = async_mode & ext_sel & tmr_sel;
  wire and_w    = f_pw & g_pw;
  wire tmr_tick = and_w & ~and_q;
  wire ext_tick = ext_clk & ~ext_q;

  assign base_tick = use_tmr ? tmr_tick : ext_tick;
  assign txd = tx_busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      f_top <= '0; f_low <= '0; g_top <= '0; g_low <= '0;
    end else if (!run && cfg_load) begin
      f_top <= fast_top; f_low <= fast_low;
      g_top <= gate_top; g_low <= gate_low;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      f_cnt <= '0; g_cnt <= '0; f_pw <= 1'b0; g_pw <= 1'b0;
    end else begin
      f_cnt <= (f_cnt == f_top) ? '0 : f_cnt + CW'(1);
      g_cnt <= (g_cnt == g_top) ? '0 : g_cnt + CW'(1);
      if (f_cnt == f_top)      f_pw <= 1'b1;
      else if (f_cnt == f_low) f_pw <= 1'b0;
      if (g_cnt == g_top)      g_pw <= 1'b1;
      else if (g_cnt == g_low) g_pw <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    ext_q <= ext_clk;
    if (rst) and_q <= 1'b0;
    else     and_q <= and_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_busy <= 1'b0; shreg <= '1; tcnt <= '0; bcnt <= '0;
    end else if (!tx_busy) begin
      if (tx_valid) begin
        shreg <= {1'b1, tx_data, 1'b0};
        tx_busy <= 1'b1;
        tcnt <= '0;
        bcnt <= '0;
      end
    end else if (base_tick) begin
      if (tcnt == T_LAST) begin
        tcnt <= '0;
        shreg <= {1'b1, shreg[FW-1:1]};
        if (bcnt == B_LAST) tx_busy <= 1'b0;
        else bcnt <= bcnt + BCW'(1);
      end else begin
        tcnt <= tcnt + TCW'(1);
      end
    end
  end
endmodule

// File: rtl/fracbaud_tx_chk.sv
module fracbaud_tx_chk (
  input logic clk,
  input logic rst,
  input logic run,
  input logic async_mode,
  input logic ext_sel,
  input logic tmr_sel,
  input logic ext_clk,
  input logic base_tick,
  input logic tx_busy,
  input logic txd
);
  wire tsel = async_mode & ext_sel & tmr_sel;

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> txd);

  assert_tick_single_R3: assert property (@(posedge clk) disable iff (rst)
    base_tick |=> !base_tick);

  assert_stopped_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (!run && $past(!run) && tsel && $past(tsel)) |-> !base_tick);

  assert_ext_edge_R6: assert property (@(posedge clk) disable iff (rst)
    (!tsel && ext_clk && !$past(ext_clk)) |-> base_tick);

  assert_start_low_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_busy) |-> !txd);

  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (tx_busy && !base_tick) |=> tx_busy);
endmodule

bind fracbaud_tx fracbaud_tx_chk u_chk (
  .clk(clk), .rst(rst), .run(run), .async_mode(async_mode),
  .ext_sel(ext_sel), .tmr_sel(tmr_sel), .ext_clk(ext_clk),
  .base_tick(base_tick), .tx_busy(tx_busy), .txd(txd)
);

// File: tb/fracbaud_tx_bench.sv
module fracbaud_tx_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0, cfg_load = 1'b0;
  logic [7:0] fast_top = '0, fast_low = '0, gate_top = '0, gate_low = '0;
  logic async_mode = 1'b1, ext_sel = 1'b1, tmr_sel = 1'b1, ext_clk = 1'b0;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic base_tick, tx_busy, txd;

  int checks = 0, failures = 0;
  logic expq[$];
  int k = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fracbaud_tx u_fracbaud_tx (
    .clk(clk), .rst(rst), .run(run), .cfg_load(cfg_load),
    .fast_top(fast_top), .fast_low(fast_low), .gate_top(gate_top), .gate_low(gate_low),
    .async_mode(async_mode), .ext_sel(ext_sel), .tmr_sel(tmr_sel), .ext_clk(ext_clk),
    .tx_valid(tx_valid), .tx_data(tx_data),
    .base_tick(base_tick), .tx_busy(tx_busy), .txd(txd)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_range(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic count_ticks(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (base_tick) c++;
    end
  endtask

  task automatic ext_toggle_count(output int c);
    c = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      ext_clk = ((i / 4) % 2) == 1;
      #1;
      if (base_tick) c++;
    end
    @(negedge clk);
    ext_clk = 1'b0;
  endtask

  task automatic configure(input logic [7:0] ft, fl, gt, gl);
    @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    fast_top = ft; fast_low = fl; gate_top = gt; gate_low = gl;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    run = 1'b1;
  endtask

  // Driver: queue expected line levels, then request the frame
  task automatic send(input logic [7:0] d, input logic [7:0] junk);
    int cyc, tk;
    expq.push_back(1'b0);
    for (int b = 0; b < 8; b++) expq.push_back(d[b]);
    expq.push_back(1'b1);
    @(negedge clk);
    tx_data = d; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk("R8 busy after request", int'(tx_busy), 1);
    cyc = 1; tk = 0;
    if (base_tick) tk++;
    while (tx_busy && cyc < 4000) begin
      if (cyc == 300) begin
        tx_data = junk; tx_valid = 1'b1;
      end else begin
        tx_valid = 1'b0;
      end
      @(negedge clk);
      cyc++;
      if (tx_busy && base_tick) tk++;
    end
    tx_valid = 1'b0;
    chk("R8 ticks per frame", tk, 160);
    chk_range("R9 cycles per frame", cyc - 1, 1696, 1714);
    chk("R8 queue drained", expq.size(), 0);
    repeat (3) @(negedge clk);
    chk("R8 mid-frame request ignored", int'(tx_busy), 0);
  endtask

  // Monitor: compare the line at mid-bit against the queue
  always @(negedge clk) begin
    if (!rst && tx_busy && base_tick) begin
      k = k + 1;
      if (k % 16 == 8) begin
        checks++;
        if (expq.size() == 0) begin
          failures++;
          $display("FAIL R7 unexpected bit actual=%0d expected=none", txd);
        end else begin
          logic e;
          e = expq.pop_front();
          if (txd !== e) begin
            failures++;
            $display("FAIL R7 bit actual=%0d expected=%0d", txd, e);
          end
        end
      end
      if (k == 160) k = 0;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int c;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 txd", int'(txd), 1);
    chk("R1 busy", int'(tx_busy), 0);
    chk("R1 tick", int'(base_tick), 0);

    fast_top = 8'd7; fast_low = 8'd3; gate_top = 8'd31; gate_low = 8'd23;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    count_ticks(40, c);
    chk("R4 stopped", c, 0);

    run = 1'b1;
    repeat (64) @(negedge clk);
    count_ticks(32, c);
    chk("R3 32-cycle window", c, 3);
    count_ticks(96, c);
    chk("R3 96-cycle window", c, 9);

    fast_top = 8'd3; fast_low = 8'd1; gate_top = 8'd0; gate_low = 8'd1;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    count_ticks(32, c);
    chk("R5 load while running", c, 3);

    configure(8'd7, 8'd3, 8'd0, 8'd1);
    repeat (16) @(negedge clk);
    count_ticks(32, c);
    chk("R2 fast top 7", c, 4);
    configure(8'd3, 8'd1, 8'd0, 8'd1);
    repeat (16) @(negedge clk);
    count_ticks(32, c);
    chk("R2 fast top 3", c, 8);

    async_mode = 1'b0;
    count_ticks(32, c);
    chk("R6 ext held low", c, 0);
    ext_toggle_count(c);
    chk("R6 ext async off", c, 4);
    async_mode = 1'b1; tmr_sel = 1'b0;
    ext_toggle_count(c);
    chk("R6 ext timer off", c, 4);
    tmr_sel = 1'b1; ext_sel = 1'b0;
    ext_toggle_count(c);
    chk("R6 ext sel off", c, 4);
    ext_sel = 1'b1;

    configure(8'd7, 8'd3, 8'd31, 8'd23);
    repeat (64) @(negedge clk);
    send(8'hA5, 8'h00);
    send(8'h3C, 8'hFF);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule